// File: doc/BRIEF.md
# Maskable Interrupt Priority Controller

This block sits in front of a small processor's sequencer and gathers five interrupt request lines. One is non-maskable. Three are restart lines, each with its own mask. One is a general vectored line, which asks the sequencer for an acknowledge sequence so that it can fetch its target. Each line is handled by its own trigger rule. The non-maskable line needs a rising edge that is still high when it is recognised. The highest restart line is an edge that is caught and held. The other two restart lines and the general line are plain levels. The controller then applies the per-line masks and a global enable flip-flop, and presents one request: the winner by fixed priority, with a source code and a fixed vector address.

Software changes the masks by writing a control byte. The masks are only reloaded when that byte's mask-set bit is set. The same write can clear the held edge of the highest restart line, and it can update a serial-out bit. A status byte reports the masks, the global enable, the pending restart lines and a serial-in bit. When the sequencer acknowledges a request, the controller clears the global enable if the request was maskable. It also clears the latch that produced the request.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the three masks are 1, the global enable is 0, the held edge and the serial-out bit are 0, and no request is presented (status byte 0x07 with serial in low).
- R2: A control write with bit 3 set loads bits 2..0 into the masks: bit 0 for the low restart line, bit 1 for the middle line and bit 2 for the high line. A mask of 1 blocks its line. A write with bit 3 clear leaves the masks unchanged.
- R3: A control write with bit 4 set clears the held edge of the high restart line, whatever the value of bit 3.
- R4: A control write with bit 6 set loads bit 7 into the serial-out output. A write with bit 6 clear leaves that output unchanged.
- R5: The status byte holds the masks in bits 2..0 and the global enable in bit 3. Bits 4, 5 and 6 are the pending flags of the low, middle and high restart lines, pending regardless of mask. Bit 7 is the synchronised serial-in bit.
- R6: An enable pulse sets the global enable and a disable pulse clears it. When both pulses arrive in the same cycle, the disable wins.
- R7: The non-maskable line is presented only after a rising edge while it stays high. Masks and the global enable do not affect it. A pulse that is gone by recognition is dropped. Once it is acknowledged, it is not presented again until a new rising edge.
- R8: A rising edge on the high restart line is held until it is cleared. The held edge is presented only when the global enable is 1 and mask bit 2 is 0.
- R9: The middle restart line, the low restart line and the general line are presented while they are high, provided the global enable is 1 and, for the restart lines, their mask is 0. They are withdrawn when the line falls.
- R10: Priority from high to low is: non-maskable (code 1), high restart (code 2), middle restart (code 3), low restart (code 4), general (code 5). Code 0 means that no request is presented.
- R11: The vector reported is 0x0024 for the non-maskable line, 0x003C for the high line, 0x0034 for the middle line and 0x002C for the low line, with the acknowledge-sequence flag at 0. The general line reports vector 0x0000 with that flag at 1.
- R12: An acknowledge of a maskable request clears the global enable, and an acknowledge of the high restart request also clears its held edge. An acknowledge of the non-maskable request leaves the global enable unchanged.
- R13: Level-triggered lines and serial in reach the outputs at the second rising clock edge after they change. Edge-triggered lines reach them at the third edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_in | input | 1 | Non-maskable request, asynchronous |
| rq_hi_in | input | 1 | High restart request, edge-triggered |
| rq_mid_in | input | 1 | Middle restart request, level |
| rq_lo_in | input | 1 | Low restart request, level |
| rq_gen_in | input | 1 | General vectored request, level |
| ser_in | input | 1 | Serial-in bit, shown in status |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_byte | input | 8 | Control byte |
| ie_set | input | 1 | Global enable set pulse |
| ie_clr | input | 1 | Global enable clear pulse |
| ack | input | 1 | Sequencer acknowledges the presented request |
| stat_byte | output | 8 | Status byte |
| ser_out | output | 1 | Serial-out register bit |
| req_valid | output | 1 | A request is presented |
| req_code | output | 3 | Source code of the presented request |
| req_vector | output | 16 | Fixed vector address of the presented request |
| req_seq | output | 1 | Request needs an acknowledge sequence for its target |

## Verification
Level lines are due at the second clock edge after the bench changes them, because they pass through a two-flop synchroniser. The held edge and the non-maskable request need one further edge for edge detection, so they are due at the third. Control writes, enable pulses and acknowledges take effect at the first edge. The bench drives every input on the falling edge and samples on a later falling edge, counted from these latencies. In the latency checks it also samples one edge early, to confirm that nothing arrives before it is due. The sweep over request levels, masks and enable waits past the longest latency before it compares the outputs with a priority result that the bench computes itself.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_NMI  = 3'd1,
    SRC_HI   = 3'd2,
    SRC_MID  = 3'd3,
    SRC_LO   = 3'd4,
    SRC_GEN  = 3'd5
  } src_e;

  localparam int CTL_MSET  = 3;
  localparam int CTL_ECLR  = 4;
  localparam int CTL_SOEN  = 6;
  localparam int CTL_SODAT = 7;
  localparam int NUM_MASK  = 3;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 6,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[g] <= '0;
          else        stg_q[g] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[g] <= '0;
          else        stg_q[g] <= stg_q[g-1];
        end
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/irq_trig.sv
module irq_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_lvl,
  input  logic hi_lvl,
  input  logic nmi_clr,
  input  logic edge_clr,
  output logic nmi_req,
  output logic hi_pend
);
  logic nmi_prev_q, hi_prev_q, nmi_pend_q, hi_edge_q;
  logic nmi_pend_d, hi_edge_d;
  logic nmi_rise, hi_rise;

  always_comb begin
    nmi_rise   = nmi_lvl & ~nmi_prev_q;
    hi_rise    = hi_lvl & ~hi_prev_q;
    nmi_pend_d = (nmi_pend_q | nmi_rise) & nmi_lvl & ~nmi_clr;
    hi_edge_d  = (hi_edge_q | hi_rise) & ~edge_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_prev_q <= 1'b0;
      hi_prev_q  <= 1'b0;
      nmi_pend_q <= 1'b0;
      hi_edge_q  <= 1'b0;
    end else begin
      nmi_prev_q <= nmi_lvl;
      hi_prev_q  <= hi_lvl;
      nmi_pend_q <= nmi_pend_d;
      hi_edge_q  <= hi_edge_d;
    end
  end

  assign nmi_req = nmi_pend_q & nmi_lvl;
  assign hi_pend = hi_edge_q;

  assert_edge_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    edge_clr |=> !hi_pend);
  assert_nmi_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_clr |=> !nmi_req);
endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
  import irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ctl_wr,
  input  logic [7:0]          ctl_byte,
  input  logic                ie_set,
  input  logic                ie_clr,
  output logic [NUM_MASK-1:0] mask,
  output logic                ie,
  output logic                ser_out
);
  logic [NUM_MASK-1:0] mask_q, mask_d;
  logic ie_q, ie_d, so_q, so_d;
  logic mask_en, so_en;

  always_comb begin
    mask_en = ctl_wr & ctl_byte[CTL_MSET];
    so_en   = ctl_wr & ctl_byte[CTL_SOEN];
    mask_d  = mask_en ? ctl_byte[NUM_MASK-1:0] : mask_q;
    so_d    = so_en ? ctl_byte[CTL_SODAT] : so_q;
    ie_d    = ie_clr ? 1'b0 : (ie_set ? 1'b1 : ie_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      ie_q   <= 1'b0;
      so_q   <= 1'b0;
    end else begin
      mask_q <= mask_d;
      ie_q   <= ie_d;
      so_q   <= so_d;
    end
  end

  assign mask    = mask_q;
  assign ie      = ie_q;
  assign ser_out = so_q;

  assert_mask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !ctl_byte[CTL_MSET]) |=> (mask_q == $past(mask_q)));
  assert_ie_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ie_clr |=> !ie_q);
  assert_so_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !ctl_byte[CTL_SOEN]) |=> $stable(so_q));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter logic [15:0] VEC_NMI = 16'h0024,
  parameter logic [15:0] VEC_HI  = 16'h003C,
  parameter logic [15:0] VEC_MID = 16'h0034,
  parameter logic [15:0] VEC_LO  = 16'h002C
) (
  input  logic                nmi_req,
  input  logic                hi_pend,
  input  logic                mid_lvl,
  input  logic                lo_lvl,
  input  logic                gen_lvl,
  input  logic [NUM_MASK-1:0] mask,
  input  logic                ie,
  output logic                valid,
  output src_e                code,
  output logic [15:0]         vector,
  output logic                seq
);
  logic hi_ok, mid_ok, lo_ok, gen_ok;

  always_comb begin
    hi_ok  = hi_pend & ie & ~mask[2];
    mid_ok = mid_lvl & ie & ~mask[1];
    lo_ok  = lo_lvl  & ie & ~mask[0];
    gen_ok = gen_lvl & ie;
    code   = SRC_NONE;
    vector = 16'h0000;
    seq    = 1'b0;
    if (nmi_req) begin
      code = SRC_NMI; vector = VEC_NMI;
    end else if (hi_ok) begin
      code = SRC_HI;  vector = VEC_HI;
    end else if (mid_ok) begin
      code = SRC_MID; vector = VEC_MID;
    end else if (lo_ok) begin
      code = SRC_LO;  vector = VEC_LO;
    end else if (gen_ok) begin
      code = SRC_GEN; seq = 1'b1;
    end
    valid = (code != SRC_NONE);
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] VEC_NMI     = 16'h0024,
  parameter logic [15:0] VEC_HI      = 16'h003C,
  parameter logic [15:0] VEC_MID     = 16'h0034,
  parameter logic [15:0] VEC_LO      = 16'h002C
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        nmi_in,
  input  logic        rq_hi_in,
  input  logic        rq_mid_in,
  input  logic        rq_lo_in,
  input  logic        rq_gen_in,
  input  logic        ser_in,
  input  logic        ctl_wr,
  input  logic [7:0]  ctl_byte,
  input  logic        ie_set,
  input  logic        ie_clr,
  input  logic        ack,
  output logic [7:0]  stat_byte,
  output logic        ser_out,
  output logic        req_valid,
  output logic [2:0]  req_code,
  output logic [15:0] req_vector,
  output logic        req_seq
);
  localparam int IN_W = 6;

  logic [IN_W-1:0]     raw, syn;
  logic                nmi_req, hi_pend;
  logic [NUM_MASK-1:0] mask;
  logic                ie;
  src_e                code;
  logic                ack_hit, clr_nmi, clr_edge, clr_ie;

  assign raw = {ser_in, rq_gen_in, rq_lo_in, rq_mid_in, rq_hi_in, nmi_in};

  irq_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
  );

  always_comb begin
    ack_hit  = ack & req_valid;
    clr_nmi  = ack_hit & (code == SRC_NMI);
    clr_edge = (ack_hit & (code == SRC_HI)) | (ctl_wr & ctl_byte[CTL_ECLR]);
    clr_ie   = ie_clr | (ack_hit & (code != SRC_NMI));
  end

  irq_trig u_trig (
    .clk(clk), .rst_n(rst_n),
    .nmi_lvl(syn[0]), .hi_lvl(syn[1]),
    .nmi_clr(clr_nmi), .edge_clr(clr_edge),
    .nmi_req(nmi_req), .hi_pend(hi_pend)
  );

  irq_mask_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr(ctl_wr), .ctl_byte(ctl_byte),
    .ie_set(ie_set), .ie_clr(clr_ie),
    .mask(mask), .ie(ie), .ser_out(ser_out)
  );

  irq_arbiter #(
    .VEC_NMI(VEC_NMI), .VEC_HI(VEC_HI), .VEC_MID(VEC_MID), .VEC_LO(VEC_LO)
  ) u_arb (
    .nmi_req(nmi_req), .hi_pend(hi_pend),
    .mid_lvl(syn[2]), .lo_lvl(syn[3]), .gen_lvl(syn[4]),
    .mask(mask), .ie(ie),
    .valid(req_valid), .code(code), .vector(req_vector), .seq(req_seq)
  );

  assign req_code  = code;
  assign stat_byte = {syn[5], hi_pend, syn[2], syn[3], ie, mask};

  assert_ack_clears_ie_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && req_valid && req_code != SRC_NMI) |=> !ie);
  assert_nmi_unblocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> (req_valid && req_code == SRC_NMI));
  assert_hi_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_code == SRC_HI) |-> (ie && !mask[2]));
  assert_code_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid == (req_code != SRC_NONE));
endmodule

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk, rst_n;
  logic nmi_in, rq_hi_in, rq_mid_in, rq_lo_in, rq_gen_in, ser_in;
  logic ctl_wr, ie_set, ie_clr, ack;
  logic [7:0] ctl_byte, stat_byte;
  logic ser_out, req_valid, req_seq;
  logic [2:0] req_code;
  logic [15:0] req_vector;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  irq_prio_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .nmi_in(nmi_in), .rq_hi_in(rq_hi_in), .rq_mid_in(rq_mid_in),
    .rq_lo_in(rq_lo_in), .rq_gen_in(rq_gen_in), .ser_in(ser_in),
    .ctl_wr(ctl_wr), .ctl_byte(ctl_byte), .ie_set(ie_set), .ie_clr(ie_clr),
    .ack(ack), .stat_byte(stat_byte), .ser_out(ser_out),
    .req_valid(req_valid), .req_code(req_code), .req_vector(req_vector),
    .req_seq(req_seq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] b);
    ctl_byte = b; ctl_wr = 1'b1;
    tick();
    ctl_wr = 1'b0; ctl_byte = 8'h00;
  endtask

  task automatic pulse_ie(input bit en);
    if (en) ie_set = 1'b1; else ie_clr = 1'b1;
    tick();
    ie_set = 1'b0; ie_clr = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    tick();
    ack = 1'b0;
  endtask

  function automatic logic [2:0] exp_code(bit nmi, bit hp, bit mid, bit lo,
                                          bit gen, logic [2:0] m, bit ie);
    if (nmi) return 3'd1;
    if (hp && ie && !m[2]) return 3'd2;
    if (mid && ie && !m[1]) return 3'd3;
    if (lo && ie && !m[0]) return 3'd4;
    if (gen && ie) return 3'd5;
    return 3'd0;
  endfunction

  function automatic logic [15:0] exp_vec(logic [2:0] c);
    case (c)
      3'd1: return 16'h0024;
      3'd2: return 16'h003C;
      3'd3: return 16'h0034;
      3'd4: return 16'h002C;
      default: return 16'h0000;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    nmi_in = 0; rq_hi_in = 0; rq_mid_in = 0; rq_lo_in = 0; rq_gen_in = 0; ser_in = 0;
    ctl_wr = 0; ctl_byte = 8'h00; ie_set = 0; ie_clr = 0; ack = 0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 status", stat_byte, 8'h07);
    chk("R1 valid", req_valid, 0);
    chk("R1 ser_out", ser_out, 0);

    // Sweep: R2 R5 R8 R9 R10 R11
    for (int v = 0; v < 256; v++) begin
      logic [2:0] m; bit ie, hp, mid, lo, gen;
      logic [2:0] ec;
      m = v[2:0]; ie = v[3]; hp = v[4]; mid = v[5]; lo = v[6]; gen = v[7];
      rq_mid_in = 0; rq_lo_in = 0; rq_gen_in = 0;
      wr_ctl({3'b000, 1'b1, 1'b1, m});
      pulse_ie(ie);
      repeat (3) tick();
      if (hp) begin
        rq_hi_in = 1; repeat (2) tick(); rq_hi_in = 0;
      end
      rq_mid_in = mid; rq_lo_in = lo; rq_gen_in = gen;
      repeat (3) tick();
      ec = exp_code(0, hp, mid, lo, gen, m, ie);
      chk("R10 sweep code", req_code, ec);
      chk("R9 sweep valid", req_valid, ec != 0);
      chk("R11 sweep vector", req_vector, exp_vec(ec));
      chk("R11 sweep seq", req_seq, ec == 3'd5);
      chk("R5 sweep status", stat_byte, {1'b0, hp, mid, lo, ie, m});
    end
    rq_mid_in = 0; rq_lo_in = 0; rq_gen_in = 0;
    wr_ctl(8'h1F);
    pulse_ie(0);
    repeat (3) tick();

    // R13 latency of level line and of edge line
    wr_ctl(8'h08); pulse_ie(1);
    rq_mid_in = 1;
    tick(); chk("R13 level early", req_valid, 0);
    tick(); chk("R13 level due", req_code, 3'd3);
    rq_mid_in = 0; repeat (3) tick();
    rq_hi_in = 1;
    tick(); tick(); chk("R13 edge early", req_valid, 0);
    tick(); chk("R13 edge due", req_code, 3'd2);
    rq_hi_in = 0; tick();

    // R12 ack of high restart clears IE and held edge
    do_ack();
    chk("R12 ie cleared", stat_byte[3], 0);
    chk("R12 edge cleared", stat_byte[6], 0);
    chk("R12 no req", req_valid, 0);

    // R7 NMI unblocked, single presentation, R12 IE kept
    wr_ctl(8'h0F);
    pulse_ie(1);
    rq_hi_in = 1; repeat (2) tick(); rq_hi_in = 0;
    wr_ctl(8'h08);
    nmi_in = 1;
    tick(); tick(); chk("R13 nmi early", req_code, 3'd2);
    tick(); chk("R7 nmi wins", req_code, 3'd1);
    chk("R11 nmi vector", req_vector, 16'h0024);
    do_ack();
    chk("R12 nmi keeps ie", stat_byte[3], 1);
    chk("R7 nmi not again", req_code, 3'd2);
    do_ack();
    nmi_in = 0; repeat (3) tick();
    nmi_in = 1; repeat (3) tick();
    chk("R7 nmi ignores ie", req_code, 3'd1);
    do_ack();
    nmi_in = 0; repeat (3) tick();
    nmi_in = 1; tick(); nmi_in = 0;
    repeat (4) begin
      tick(); chk("R7 short pulse dropped", req_valid, 0);
    end

    // R3 bit4 clears held edge without bit3, masks unchanged
    wr_ctl(8'h0D);
    rq_hi_in = 1; repeat (3) tick(); rq_hi_in = 0;
    chk("R3 pending before", stat_byte[6], 1);
    wr_ctl(8'h10);
    chk("R3 pending cleared", stat_byte[6], 0);
    chk("R2 masks kept", stat_byte[2:0], 3'b101);

    // R4 serial out
    wr_ctl(8'hC0); chk("R4 so set", ser_out, 1);
    wr_ctl(8'h00); chk("R4 so hold", ser_out, 1);
    wr_ctl(8'h40); chk("R4 so clear", ser_out, 0);

    // R5 serial in
    ser_in = 1; tick(); tick();
    chk("R5 ser_in bit", stat_byte[7], 1);
    ser_in = 0; tick(); tick();

    // R6 enable set/clear, clear wins
    pulse_ie(1); chk("R6 set", stat_byte[3], 1);
    ie_set = 1; ie_clr = 1; tick(); ie_set = 0; ie_clr = 0;
    chk("R6 clear wins", stat_byte[3], 0);

    // R12 general ack clears IE
    pulse_ie(1);
    rq_gen_in = 1; repeat (2) tick();
    chk("R11 gen seq", req_seq, 1);
    do_ack();
    chk("R12 gen ack ie", stat_byte[3], 0);
    chk("R9 gen blocked", req_valid, 0);
    rq_gen_in = 0; tick();

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule